// File: doc/BRIEF.md
# Approximate Dadda Multiplier with Selectable 4:2 Compressors

This block multiplies two unsigned 8-bit operands and returns a 16-bit product in purely combinational logic. AND gates form eight partial-product rows. Two reduction phases then shrink the rows: the first phase takes eight rows down to four, and the second phase takes four rows down to two. A carry-propagate adder turns the last two rows into the product.

Each phase is built from 4:2 compressor cells and full-adder rows. A build-time mode chooses whether the compressor cells in each phase are exact or approximate. This gives three variants: fully exact, approximate in the second phase only, and approximate in both phases. The approximate cell trades a small, one-sided loss of accuracy for simpler logic. It only ever removes value and never adds it.

A small control unit detects a zero operand and forces the product to zero. That result is therefore exact in every variant. The block is meant for error-tolerant datapaths, such as pixel scaling, where the variant is fixed when the design is built.

Top module: `daddaApproxMul`

## Requirements
- R1: With the mode set to fully exact, `product` equals `opA*opB` for all 65536 operand pairs.
- R2: In every mode, when `opA` or `opB` is zero, `product` is zero.
- R3: The compressor cell takes four bits and drives `sumOut` (weight 1), `carryOut` (weight 2) and `coutOut` (weight 2). The exact cell's weighted output equals the number of ones at its inputs. The approximate cell does the same, except that on the four patterns with exactly three ones it clears `sumOut` and yields 2.
- R4: In every mode, `product` is never larger than `opA*opB`.
- R5: In every mode, when either operand has exactly one bit set, `product` equals `opA*opB`.
- R6: With approximation in the second phase only, `product` equals `opA*opB` whenever `opB[7:4]` is zero or `opB[3:0]` is zero. Rows 0 to 3 use `opB[3:0]` and rows 4 to 7 use `opB[7:4]`.
- R7: With approximation in both phases, first-phase cells take effect: `7*7` yields at most 45.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 8 | Multiplicand, unsigned |
| opB | input | 8 | Multiplier, unsigned; bit i selects partial-product row i |
| product | output | 16 | Product, exact or approximated according to the build mode |

## Verification
Every one of the 65536 operand pairs is applied to all three variants at once.

- **Exact variant:** compared against arithmetic multiplication.
- **Approximate variants:** checked against the one-sided bound.
- **Single-bit operands:** these never stack three ones in a column, so an error there points at the adder wiring rather than at the approximation.
- **Half-zero multipliers:** a multiplier with one zero half feeds the second phase only two live rows. This separates second-phase-only approximation from full approximation.
- **The 7×7 case:** this is where three ones meet in the first phase, and it confirms that first-phase cells really are approximate in the full variant.

The cell itself is swept over its 16 input patterns in both flavours.

// File: rtl/dmulPkg.sv
package dmulPkg;

  // Build-time choice of where approximate compressor cells are used.
  typedef enum logic [1:0] {
    APPROX_NONE = 2'd0,  // every compressor exact
    APPROX_LATE = 2'd1,  // second phase approximate
    APPROX_ALL  = 2'd2   // both phases approximate
  } approxMode_e;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic forceZero;
  } ctlStrb_t;

  // Rows fed to one compressor row.
  localparam int unsigned COMP_IN = 4;

endpackage

// File: rtl/dmulComp42.sv
// Four-input compressor cell without carry-in.
// Output value = sumOut + 2*carryOut + 2*coutOut.
module dmulComp42 #(
  parameter bit APPROX = 1'b0
) (
  input  logic [3:0] bitsIn,
  output logic       sumOut,
  output logic       carryOut,
  output logic       coutOut
);

  logic [2:0] ones;

  always_comb begin
    ones = 3'(bitsIn[0]) + 3'(bitsIn[1]) + 3'(bitsIn[2]) + 3'(bitsIn[3]);
  end

  assign carryOut = (ones >= 3'd2);
  assign coutOut  = (ones == 3'd4);

  generate
    if (APPROX) begin : gApprox
      // Minterms with three ones lose their low bit (1 -> 0 only).
      assign sumOut = (ones == 3'd1);
    end else begin : gExact
      assign sumOut = ones[0];
    end
  endgenerate

endmodule

// File: rtl/dmulRowComp.sv
// Applies a compressor cell to every column of four equal-width rows.
// The top column can never hold more than one set bit, because the total
// never exceeds the largest product, so it needs only a parity gate.
module dmulRowComp #(
  parameter int unsigned W      = 16,
  parameter bit          APPROX = 1'b0
) (
  input  logic [W-1:0] rowA,
  input  logic [W-1:0] rowB,
  input  logic [W-1:0] rowC,
  input  logic [W-1:0] rowD,
  output logic [W-1:0] sumW,
  output logic [W-1:0] carW,
  output logic [W-1:0] couW
);

  logic [W-2:0] carRaw;
  logic [W-2:0] couRaw;

  genvar c;
  generate
    for (c = 0; c < W - 1; c++) begin : gCol
      dmulComp42 #(.APPROX(APPROX)) uCell (
        .bitsIn  ({rowD[c], rowC[c], rowB[c], rowA[c]}),
        .sumOut  (sumW[c]),
        .carryOut(carRaw[c]),
        .coutOut (couRaw[c])
      );
    end
  endgenerate

  assign sumW[W-1] = rowA[W-1] ^ rowB[W-1] ^ rowC[W-1] ^ rowD[W-1];
  assign carW      = {carRaw, 1'b0};
  assign couW      = {couRaw, 1'b0};

endmodule

// File: rtl/dmulZeroCtl.sv
// Control side: raises the zero strobe when either operand is zero.
module dmulZeroCtl
  import dmulPkg::*;
#(
  parameter int unsigned OP_W = 8
) (
  input  logic [OP_W-1:0] opA,
  input  logic [OP_W-1:0] opB,
  output ctlStrb_t        strb
);

  always_comb begin
    strb           = '0;
    strb.forceZero = (opA == '0) || (opB == '0);
  end

endmodule

// File: rtl/dmulDatapath.sv
// Partial products, two reduction phases and the final adder.
module dmulDatapath
  import dmulPkg::*;
#(
  parameter int unsigned OP_W      = 8,
  parameter bit          APPROX_P1 = 1'b0,
  parameter bit          APPROX_P2 = 1'b0
) (
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  input  ctlStrb_t          strb,
  output logic [2*OP_W-1:0] product
);

  localparam int unsigned PROD_W = 2 * OP_W;
  localparam int unsigned ROWS   = OP_W;
  localparam int unsigned GROUPS = ROWS / COMP_IN;
  localparam int unsigned MIDS   = 2 * GROUPS;

  // Full-adder row: three rows in, {carry row, sum row} out.
  function automatic logic [2*PROD_W-1:0] faRow(input logic [PROD_W-1:0] x,
                                                 input logic [PROD_W-1:0] y,
                                                 input logic [PROD_W-1:0] z);
    logic [PROD_W-1:0] s;
    logic [PROD_W-2:0] m;
    s = x ^ y ^ z;
    m = (x[PROD_W-2:0] & y[PROD_W-2:0]) |
        (x[PROD_W-2:0] & z[PROD_W-2:0]) |
        (y[PROD_W-2:0] & z[PROD_W-2:0]);
    return {m, 1'b0, s};
  endfunction

  logic [PROD_W-1:0] pp  [ROWS];
  logic [PROD_W-1:0] s1  [GROUPS];
  logic [PROD_W-1:0] c1  [GROUPS];
  logic [PROD_W-1:0] d1  [GROUPS];
  logic [PROD_W-1:0] mid [MIDS];
  logic [PROD_W-1:0] s2, c2, d2, finX, finY, sumAll;

  // Partial products: one AND per operand bit pair.
  genvar r, g;
  generate
    for (r = 0; r < ROWS; r++) begin : gPp
      assign pp[r] = (PROD_W'(opA) & {PROD_W{opB[r]}}) << r;
    end

    // Phase one: each group of four rows -> three -> two.
    for (g = 0; g < GROUPS; g++) begin : gPh1
      dmulRowComp #(.W(PROD_W), .APPROX(APPROX_P1)) uRow (
        .rowA(pp[COMP_IN*g]),
        .rowB(pp[COMP_IN*g+1]),
        .rowC(pp[COMP_IN*g+2]),
        .rowD(pp[COMP_IN*g+3]),
        .sumW(s1[g]),
        .carW(c1[g]),
        .couW(d1[g])
      );
      assign {mid[2*g+1], mid[2*g]} = faRow(s1[g], c1[g], d1[g]);
    end
  endgenerate

  // Phase two: four rows -> three -> two.
  dmulRowComp #(.W(PROD_W), .APPROX(APPROX_P2)) uPh2 (
    .rowA(mid[0]),
    .rowB(mid[1]),
    .rowC(mid[2]),
    .rowD(mid[3]),
    .sumW(s2),
    .carW(c2),
    .couW(d2)
  );

  assign {finY, finX} = faRow(s2, c2, d2);
  assign sumAll       = finX + finY;
  assign product      = strb.forceZero ? '0 : sumAll;

endmodule

// File: rtl/daddaApproxMul.sv
module daddaApproxMul
  import dmulPkg::*;
#(
  parameter int unsigned OP_W        = 8,
  parameter approxMode_e APPROX_MODE = APPROX_NONE
) (
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic [2*OP_W-1:0] product
);

  localparam bit P1_APPROX = (APPROX_MODE == APPROX_ALL);
  localparam bit P2_APPROX = (APPROX_MODE != APPROX_NONE);

  ctlStrb_t strb;

  dmulZeroCtl #(.OP_W(OP_W)) uCtl (
    .opA (opA),
    .opB (opB),
    .strb(strb)
  );

  dmulDatapath #(
    .OP_W     (OP_W),
    .APPROX_P1(P1_APPROX),
    .APPROX_P2(P2_APPROX)
  ) uDp (
    .opA    (opA),
    .opB    (opB),
    .strb   (strb),
    .product(product)
  );

endmodule

// File: rtl/dmulChecker.sv
module dmulChecker
  import dmulPkg::*;
#(
  parameter int unsigned OP_W        = 8,
  parameter approxMode_e APPROX_MODE = APPROX_NONE
) (
  input logic [OP_W-1:0]   opA,
  input logic [OP_W-1:0]   opB,
  input logic [2*OP_W-1:0] product
);

  localparam int unsigned PROD_W = 2 * OP_W;
  localparam int unsigned HALF   = OP_W / 2;

  logic [PROD_W-1:0] trueProd;

  always_comb begin
    trueProd = PROD_W'(opA) * PROD_W'(opB);
    if (!$isunknown({opA, opB, product})) begin
      if (opA == '0 || opB == '0) begin
        assert_zero_result_R2: assert (product == '0)
          else $error("zero operand gave nonzero product");
      end
      assert_no_excess_R4: assert (product <= trueProd)
        else $error("product above true value");
      if (APPROX_MODE == APPROX_NONE) begin
        assert_exact_product_R1: assert (product == trueProd)
          else $error("exact mode mismatch");
      end
      if ($countones(opA) == 1 || $countones(opB) == 1) begin
        assert_single_bit_exact_R5: assert (product == trueProd)
          else $error("single-bit operand not exact");
      end
      if (APPROX_MODE == APPROX_LATE &&
          (opB[OP_W-1:HALF] == '0 || opB[HALF-1:0] == '0)) begin
        assert_late_half_exact_R6: assert (product == trueProd)
          else $error("late-only mode not exact with half-zero multiplier");
      end
    end
  end

endmodule

bind daddaApproxMul dmulChecker #(
  .OP_W       (OP_W),
  .APPROX_MODE(APPROX_MODE)
) uChk (
  .opA    (opA),
  .opB    (opB),
  .product(product)
);

// File: tb/sim_daddaApproxMul.sv
`timescale 1ns/1ps
module sim_daddaApproxMul;
  import dmulPkg::*;

  logic clk = 1'b0;
  logic rst;
  always #2 clk = ~clk;  // 250 MHz

  logic [7:0]  opA, opB;
  logic [15:0] prodExact, prodLate, prodAll;
  logic [3:0]  cellIn;
  logic        eS, eC, eD, aS, aC, aD;

  int total = 0;
  int bad   = 0;

  daddaApproxMul #(.OP_W(8), .APPROX_MODE(APPROX_NONE)) u0 (
    .opA(opA), .opB(opB), .product(prodExact));
  daddaApproxMul #(.OP_W(8), .APPROX_MODE(APPROX_LATE)) u1 (
    .opA(opA), .opB(opB), .product(prodLate));
  daddaApproxMul #(.OP_W(8), .APPROX_MODE(APPROX_ALL)) u2 (
    .opA(opA), .opB(opB), .product(prodAll));

  dmulComp42 #(.APPROX(1'b0)) uCellE (
    .bitsIn(cellIn), .sumOut(eS), .carryOut(eC), .coutOut(eD));
  dmulComp42 #(.APPROX(1'b1)) uCellA (
    .bitsIn(cellIn), .sumOut(aS), .carryOut(aC), .coutOut(aD));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, opA, opB, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    int allMiss;
    allMiss = 0;
    rst    = 1'b1;
    opA    = '0;
    opB    = '0;
    cellIn = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: initial all-zero operands give zero in each variant
    chk(prodExact == 16'd0, "R2 init exact", int'(prodExact), 0);
    chk(prodLate  == 16'd0, "R2 init late",  int'(prodLate),  0);
    chk(prodAll   == 16'd0, "R2 init all",   int'(prodAll),   0);

    // R3: both compressor flavours over all 16 patterns
    for (int p = 0; p < 16; p++) begin
      int n, eVal, aVal, aExp;
      @(posedge clk);
      cellIn = p[3:0];
      @(negedge clk);
      n    = int'(p[0]) + int'(p[1]) + int'(p[2]) + int'(p[3]);
      eVal = int'(eS) + 2 * int'(eC) + 2 * int'(eD);
      aVal = int'(aS) + 2 * int'(aC) + 2 * int'(aD);
      aExp = (n == 3) ? 2 : n;
      chk(eVal == n,    "R3 exact cell",  eVal, n);
      chk(aVal == aExp, "R3 approx cell", aVal, aExp);
    end

    // Exhaustive operand sweep over the three variants
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        int want;
        bit oneHot;
        @(posedge clk);
        opA = a[7:0];
        opB = b[7:0];
        @(negedge clk);
        want = a * b;
        chk(int'(prodExact) == want, "R1 exact", int'(prodExact), want);
        chk(int'(prodLate) <= want, "R4 late bound", int'(prodLate), want);
        chk(int'(prodAll)  <= want, "R4 all bound",  int'(prodAll),  want);
        if (a == 0 || b == 0) begin
          chk(prodLate == 16'd0, "R2 late zero", int'(prodLate), 0);
          chk(prodAll  == 16'd0, "R2 all zero",  int'(prodAll),  0);
        end
        oneHot = ($countones(a[7:0]) == 1) || ($countones(b[7:0]) == 1);
        if (oneHot) begin
          chk(int'(prodLate) == want, "R5 late single-bit", int'(prodLate), want);
          chk(int'(prodAll)  == want, "R5 all single-bit",  int'(prodAll),  want);
        end
        if (b[7:4] == 4'd0 || b[3:0] == 4'd0) begin
          chk(int'(prodLate) == want, "R6 late half-zero", int'(prodLate), want);
        end
        if (a == 7 && b == 7) begin
          chk(int'(prodAll) <= 45, "R7 all 7x7", int'(prodAll), 45);
        end
        if (int'(prodAll) != want) allMiss++;
      end
    end
    // R7: full approximation differs from exact somewhere
    chk(allMiss > 0, "R7 all mismatches", allMiss, 1);
    finishRun();
  end

endmodule